// File: doc/BRIEF.md
# Dual-Mode DPLL Phase Detector

This block measures the phase error between a DPLL's reference clock and its feedback clock. Both clocks arrive as plain levels and are sampled in a fast system-clock domain. The error is the number of system-clock ticks between the two rising edges. It is reported as a signed 16-bit value: a positive value means the feedback edge came after the reference edge.

The detector has two modes. In phase/frequency mode it pairs edges in arrival order and can capture errors up to one full reference period in either direction. In nearest-edge mode it compares each reference edge with whichever feedback edge lies closest to it, before or after, so the error never exceeds half a period. A lost reference cycle in this mode never turns into a cycle-slip correction.

The mode is chosen on every reference edge from three inputs: the lock indication, the multicycle-detector enable and a force bit. A compile-time variant keeps nearest-edge mode on at all times. A slow reference (period at or above a low-rate tick threshold) always uses phase/frequency mode. A reference gap of 1.5 nominal periods is treated as a missing edge.

Top module: `phdet_dual`

## Requirements
- R1: With `ne_mode`=0, a reference edge and a feedback edge are paired in arrival order, and the result is the tick distance between them: positive when the feedback edge is later, 0 when both edges land in the same tick. The magnitude is limited to REF_PERIOD. Two reference edges with no feedback edge between them give +REF_PERIOD, and two feedback edges with no reference edge between them give -REF_PERIOD.
- R2: With `ne_mode`=1, each reference edge is compared with the nearest feedback edge, past or following. If the two are equally distant, the past edge is used (negative result). The magnitude is limited to REF_PERIOD/2.
- R3: `err_valid` is high for exactly one clock for each new result. `phase_err` holds its value between results. `err_up` is 1 exactly when `phase_err` is greater than zero.
- R4: The mode changes only on a reference edge. At that edge `ne_mode` becomes 1 when `lock_in`=1, `mcpd_en`=0 and `force_pf`=0, and becomes 0 otherwise. The edge that changes the mode is evaluated in the new mode, and any comparison still pending is discarded.
- R5: `force_pf`=1 keeps `ne_mode`=0, even while `lock_in`=1 and `mcpd_en`=0.
- R6: When `lock_in` drops, `ne_mode` returns to 0 on the next reference edge.
- R7: With NE_FIXED=1 and a fast reference, `ne_mode` is 1 from reset onward, whatever the values of `lock_in`, `mcpd_en` and `force_pf`.
- R8: When REF_PERIOD >= LOWRATE_TICKS, `ne_mode` stays 0 in both variants.
- R9: If no reference edge arrives within 1.5*REF_PERIOD ticks of the previous one, `miss_flag` goes to 1. While it is set, the pending comparison is discarded, no result is produced, `phase_err` holds, and feedback edges are ignored. The next reference edge clears the flag. In nearest-edge mode, a single missing reference cycle therefore produces no result other than the true phase.
- R10: After reset, `phase_err`=0, `err_up`=0, `err_valid`=0 and `miss_flag`=0, and `ne_mode`=0 for the default variant. An input edge that completes a measurement shows up at the outputs on the (SYNC_STAGES+1)-th rising clock after the first clock that samples it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Reference clock level |
| fb_clk_in | input | 1 | Feedback clock level |
| lock_in | input | 1 | Phase-lock indication |
| mcpd_en | input | 1 | Multicycle detector enabled (blocks nearest-edge mode) |
| force_pf | input | 1 | Force phase/frequency mode |
| phase_err | output | 16 | Signed phase error in ticks, positive = feedback lags |
| err_up | output | 1 | Sign of the last result (1 = positive) |
| err_valid | output | 1 | One-clock strobe for a new result |
| ne_mode | output | 1 | Current mode: 0 phase/frequency, 1 nearest-edge |
| miss_flag | output | 1 | Missing reference edge detected |

## Verification
The hardest case to reach is a reference cycle that goes missing while the detector is already in nearest-edge mode. The feedback clock keeps running through the gap, so a faulty design would emit a spurious negative correction. To get there, the stimulus first raises the lock flag and waits for the mode to switch. It then suppresses exactly one reference high phase in the generator and checks that every result in the window still equals the true lag and that the missing-edge flag rose. Exact ties between the past and next feedback edges, and feedback periods far from the reference period, are produced by aligning the bench's two free-running phase counters.

// File: rtl/phdet_pkg.sv
package phdet_pkg;

    parameter int ERR_W = 16;

    typedef enum logic {
        MODE_PF = 1'b0,
        MODE_NE = 1'b1
    } det_mode_e;

    typedef enum logic [1:0] {
        PF_IDLE      = 2'd0,
        PF_REF_FIRST = 2'd1,
        PF_FB_FIRST  = 2'd2
    } pf_state_e;

    typedef struct packed {
        logic                    valid;
        logic signed [ERR_W-1:0] err;
    } det_result_t;

    function automatic logic [ERR_W-1:0] inc_sat(input logic [ERR_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    function automatic logic signed [ERR_W-1:0] sat_mag(
        input logic [ERR_W-1:0] mag,
        input logic [ERR_W-1:0] lim,
        input logic             neg
    );
        logic [ERR_W-1:0] m;
        m = (mag > lim) ? lim : mag;
        return neg ? -$signed(m) : $signed(m);
    endfunction

endpackage

// File: rtl/phdet_edge_sync.sv
module phdet_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pulse
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign pulse = chain[STAGES-1] & ~last;

    // R10: an edge pulse lasts one clock
    a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/phdet_mode_ctrl.sv
module phdet_mode_ctrl
    import phdet_pkg::*;
#(
    parameter bit NE_FIXED = 1'b0,
    parameter bit LOW_RATE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ref_pulse,
    input  logic      lock_in,
    input  logic      mcpd_en,
    input  logic      force_pf,
    output det_mode_e mode_q,
    output det_mode_e mode_now,
    output logic      mode_chg
);
    localparam det_mode_e RST_MODE = (NE_FIXED && !LOW_RATE) ? MODE_NE : MODE_PF;

    logic ne_ok;

    generate
        if (LOW_RATE) begin : g_slow
            assign ne_ok = 1'b0;
        end else if (NE_FIXED) begin : g_fixed
            assign ne_ok = 1'b1;
        end else begin : g_auto
            assign ne_ok = lock_in & ~mcpd_en & ~force_pf;
        end
    endgenerate

    always_comb begin
        if (ref_pulse) mode_now = ne_ok ? MODE_NE : MODE_PF;
        else           mode_now = mode_q;
        mode_chg = (mode_now != mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= RST_MODE;
        else     mode_q <= mode_now;
    end

    // R4: mode only moves on a reference edge
    a_r4_mode_on_ref_only: assert property (@(posedge clk) disable iff (rst)
        !ref_pulse |=> $stable(mode_q));
    // R5: force keeps phase/frequency mode
    a_r5_force_keeps_pf: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && force_pf && !NE_FIXED) |=> (mode_q == MODE_PF));
    // R6: lock loss returns to phase/frequency mode
    a_r6_lock_loss_pf: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && !lock_in && !NE_FIXED) |=> (mode_q == MODE_PF));
    // R8: slow reference never uses nearest-edge mode
    a_r8_low_rate_pf: assert property (@(posedge clk) disable iff (rst)
        LOW_RATE |-> (mode_q == MODE_PF));

endmodule

// File: rtl/phdet_miss_mon.sv
module phdet_miss_mon
    import phdet_pkg::*;
#(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    output logic miss_q,
    output logic miss_set
);
    localparam logic [ERR_W-1:0] LIM = ERR_W'(LIMIT);

    logic [ERR_W-1:0] gap_q;

    assign miss_set = !ref_pulse && (gap_q == LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            miss_q <= 1'b0;
        end else begin
            gap_q <= ref_pulse ? ERR_W'(1) : inc_sat(gap_q);
            if (ref_pulse)     miss_q <= 1'b0;
            else if (miss_set) miss_q <= 1'b1;
        end
    end

    // R9: the flag drops on the next reference edge
    a_r9_clear_on_ref: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !miss_q);

endmodule

// File: rtl/phdet_core.sv
module phdet_core
    import phdet_pkg::*;
#(
    parameter int PERIOD = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_pulse,
    input  logic        fb_pulse,
    input  det_mode_e   mode_now,
    input  logic        mode_chg,
    input  logic        miss_q,
    input  logic        miss_set,
    output det_result_t res_q
);
    localparam logic [ERR_W-1:0]        FULL   = ERR_W'(PERIOD);
    localparam logic [ERR_W-1:0]        HALF   = ERR_W'(PERIOD / 2);
    localparam logic signed [ERR_W-1:0] FULL_S = ERR_W'(PERIOD);
    localparam logic signed [ERR_W-1:0] HALF_S = ERR_W'(PERIOD / 2);

    pf_state_e        pf_st, pf_st_n, pf_cur;
    logic [ERR_W-1:0] pf_cnt, pf_cnt_n;
    logic             ne_wait, ne_wait_n, ne_live;
    logic [ERR_W-1:0] ne_cnt, ne_cnt_n;
    logic [ERR_W-1:0] ne_past, ne_past_n;
    logic [ERR_W-1:0] fb_age, age_now;
    logic             blocked;
    det_result_t      res_n;

    assign age_now = fb_pulse ? '0 : fb_age;
    assign blocked = miss_set || (miss_q && !ref_pulse);

    always_comb begin
        pf_st_n   = pf_st;
        pf_cnt_n  = inc_sat(pf_cnt);
        ne_wait_n = ne_wait;
        ne_cnt_n  = inc_sat(ne_cnt);
        ne_past_n = ne_past;
        res_n     = '{valid: 1'b0, err: res_q.err};
        pf_cur    = mode_chg ? PF_IDLE : pf_st;
        ne_live   = ne_wait && !mode_chg;

        if (blocked) begin
            pf_st_n   = PF_IDLE;
            ne_wait_n = 1'b0;
        end else if (mode_now == MODE_PF) begin
            ne_wait_n = 1'b0;
            pf_st_n   = pf_cur;
            if (ref_pulse && fb_pulse) begin
                res_n   = '{valid: 1'b1, err: '0};
                pf_st_n = PF_IDLE;
            end else if (ref_pulse) begin
                case (pf_cur)
                    PF_FB_FIRST: begin
                        res_n   = '{valid: 1'b1, err: sat_mag(pf_cnt, FULL, 1'b1)};
                        pf_st_n = PF_IDLE;
                    end
                    PF_REF_FIRST: begin
                        res_n    = '{valid: 1'b1, err: sat_mag(FULL, FULL, 1'b0)};
                        pf_cnt_n = ERR_W'(1);
                    end
                    default: begin
                        pf_st_n  = PF_REF_FIRST;
                        pf_cnt_n = ERR_W'(1);
                    end
                endcase
            end else if (fb_pulse) begin
                case (pf_cur)
                    PF_REF_FIRST: begin
                        res_n   = '{valid: 1'b1, err: sat_mag(pf_cnt, FULL, 1'b0)};
                        pf_st_n = PF_IDLE;
                    end
                    PF_FB_FIRST: begin
                        res_n    = '{valid: 1'b1, err: sat_mag(FULL, FULL, 1'b1)};
                        pf_cnt_n = ERR_W'(1);
                    end
                    default: begin
                        pf_st_n  = PF_FB_FIRST;
                        pf_cnt_n = ERR_W'(1);
                    end
                endcase
            end
        end else begin
            pf_st_n = PF_IDLE;
            if (ref_pulse) begin
                if (age_now == '0) begin
                    res_n     = '{valid: 1'b1, err: '0};
                    ne_wait_n = 1'b0;
                end else begin
                    ne_wait_n = 1'b1;
                    ne_cnt_n  = ERR_W'(1);
                    ne_past_n = age_now;
                end
            end else if (ne_live) begin
                if (fb_pulse && (ne_cnt < ne_past)) begin
                    res_n     = '{valid: 1'b1, err: sat_mag(ne_cnt, HALF, 1'b0)};
                    ne_wait_n = 1'b0;
                end else if (ne_cnt >= ne_past) begin
                    res_n     = '{valid: 1'b1, err: sat_mag(ne_past, HALF, 1'b1)};
                    ne_wait_n = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_st   <= PF_IDLE;
            pf_cnt  <= '0;
            ne_wait <= 1'b0;
            ne_cnt  <= '0;
            ne_past <= '0;
            fb_age  <= '1;
            res_q   <= '0;
        end else begin
            pf_st   <= pf_st_n;
            pf_cnt  <= pf_cnt_n;
            ne_wait <= ne_wait_n;
            ne_cnt  <= ne_cnt_n;
            ne_past <= ne_past_n;
            fb_age  <= fb_pulse ? ERR_W'(1) : inc_sat(fb_age);
            res_q   <= res_n;
        end
    end

    // R1: no result exceeds one full period
    a_r1_full_bound: assert property (@(posedge clk) disable iff (rst)
        res_q.valid |-> (res_q.err <= FULL_S && res_q.err >= -FULL_S));
    // R2: nearest-edge results stay within half a period
    a_r2_half_bound: assert property (@(posedge clk) disable iff (rst)
        (mode_now == MODE_NE && !blocked) |=>
            (!res_q.valid || (res_q.err <= HALF_S && res_q.err >= -HALF_S)));
    // R9: nothing is reported while a reference edge is missing
    a_r9_no_result_when_missing: assert property (@(posedge clk) disable iff (rst)
        miss_q |-> !res_q.valid);
    // R9: the error output holds while a reference edge is missing
    a_r9_hold_when_missing: assert property (@(posedge clk) disable iff (rst)
        miss_q |-> $stable(res_q.err));

endmodule

// File: rtl/phdet_dual.sv
module phdet_dual
    import phdet_pkg::*;
#(
    parameter int REF_PERIOD    = 40,
    parameter int LOWRATE_TICKS = 25000,
    parameter bit NE_FIXED      = 1'b0,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_clk_in,
    input  logic                    fb_clk_in,
    input  logic                    lock_in,
    input  logic                    mcpd_en,
    input  logic                    force_pf,
    output logic signed [ERR_W-1:0] phase_err,
    output logic                    err_up,
    output logic                    err_valid,
    output logic                    ne_mode,
    output logic                    miss_flag
);
    localparam bit LOW_RATE   = (REF_PERIOD >= LOWRATE_TICKS);
    localparam int MISS_LIMIT = REF_PERIOD + REF_PERIOD / 2;

    logic        ref_pulse, fb_pulse;
    det_mode_e   mode_q, mode_now;
    logic        mode_chg;
    logic        miss_q, miss_set;
    det_result_t res;

    phdet_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst(rst), .din(ref_clk_in), .pulse(ref_pulse));

    phdet_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst(rst), .din(fb_clk_in), .pulse(fb_pulse));

    phdet_mode_ctrl #(.NE_FIXED(NE_FIXED), .LOW_RATE(LOW_RATE)) u_mode (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .lock_in(lock_in),
        .mcpd_en(mcpd_en), .force_pf(force_pf), .mode_q(mode_q),
        .mode_now(mode_now), .mode_chg(mode_chg));

    phdet_miss_mon #(.LIMIT(MISS_LIMIT)) u_miss (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse),
        .miss_q(miss_q), .miss_set(miss_set));

    phdet_core #(.PERIOD(REF_PERIOD)) u_core (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .mode_now(mode_now), .mode_chg(mode_chg), .miss_q(miss_q),
        .miss_set(miss_set), .res_q(res));

    assign phase_err = res.err;
    assign err_valid = res.valid;
    assign err_up    = !res.err[ERR_W-1] && (res.err != '0);
    assign ne_mode   = (mode_q == MODE_NE);
    assign miss_flag = miss_q;

    // R3: a sign flag only accompanies a positive error
    a_r3_sign_matches: assert property (@(posedge clk) disable iff (rst)
        err_up |-> (phase_err > 0));

endmodule

// File: tb/phdet_dual_test.sv
`timescale 1ns/1ps
module phdet_dual_test;
    localparam int RP  = 40;
    localparam int H   = RP / 2;
    localparam int MISS = RP + RP / 2;
    localparam int CAP = 65535;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk = 1'b0, fb_clk = 1'b0;
    logic lock = 1'b0, mcpd = 1'b0, force_pf = 1'b0;

    logic signed [15:0] perr, perr_f, perr_s;
    logic up, vld, nem, miss;
    logic up_f, vld_f, nem_f, miss_f;
    logic up_s, vld_s, nem_s, miss_s;

    always #2.5 clk = ~clk;

    phdet_dual #(.REF_PERIOD(RP)) uut (
        .clk(clk), .rst(rst), .ref_clk_in(ref_clk), .fb_clk_in(fb_clk),
        .lock_in(lock), .mcpd_en(mcpd), .force_pf(force_pf),
        .phase_err(perr), .err_up(up), .err_valid(vld), .ne_mode(nem), .miss_flag(miss));

    phdet_dual #(.REF_PERIOD(RP), .NE_FIXED(1'b1)) uut_fixed (
        .clk(clk), .rst(rst), .ref_clk_in(ref_clk), .fb_clk_in(fb_clk),
        .lock_in(lock), .mcpd_en(mcpd), .force_pf(force_pf),
        .phase_err(perr_f), .err_up(up_f), .err_valid(vld_f), .ne_mode(nem_f), .miss_flag(miss_f));

    phdet_dual #(.REF_PERIOD(RP), .LOWRATE_TICKS(RP)) uut_slow (
        .clk(clk), .rst(rst), .ref_clk_in(ref_clk), .fb_clk_in(fb_clk),
        .lock_in(lock), .mcpd_en(mcpd), .force_pf(force_pf),
        .phase_err(perr_s), .err_up(up_s), .err_valid(vld_s), .ne_mode(nem_s), .miss_flag(miss_s));

    int checks = 0, fails = 0;
    bit done = 0, started = 0;

    // stimulus generator state
    bit gen_en = 0, skip_req = 0, skipping = 0;
    int rph = 0, fph = 0, fper = RP;
    bit r0, r1, r2, r3, f0, f1, f2, f3;

    // reference model state
    int m_mode, m_st, m_cnt, m_wait, m_wcnt, m_a, m_age, m_gap, m_miss, m_err, m_valid;

    // observation
    int last_err = 0;
    bit saw_pos_full = 0, saw_neg_full = 0, saw_miss = 0;
    int wrong_in_window = 0;

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic emit(input int v);
        m_err = v;
        m_valid = 1;
    endtask

    task automatic model_step(input bit r, input bit f);
        int a, st, ncnt, nw;
        bit ne_ok, mn, chg, mset, blk, wt;
        if (rst) begin
            m_mode = 0; m_st = 0; m_cnt = 0; m_wait = 0; m_wcnt = 0; m_a = 0;
            m_age = CAP; m_gap = 0; m_miss = 0; m_err = 0; m_valid = 0;
            return;
        end
        ne_ok = lock && !mcpd && !force_pf;
        mn    = r ? ne_ok : m_mode[0];
        chg   = (mn != m_mode[0]);
        mset  = !r && (m_gap == MISS);
        blk   = mset || (m_miss != 0 && !r);
        a     = f ? 0 : m_age;
        m_valid = 0;
        ncnt = imin(m_cnt + 1, CAP);
        nw   = imin(m_wcnt + 1, CAP);
        if (blk) begin
            m_st = 0; m_wait = 0;
        end else if (!mn) begin
            m_wait = 0;
            st = chg ? 0 : m_st;
            if (r && f) begin emit(0); st = 0; end
            else if (r) begin
                if (st == 2) begin emit(-imin(m_cnt, RP)); st = 0; end
                else if (st == 1) begin emit(RP); ncnt = 1; end
                else begin st = 1; ncnt = 1; end
            end else if (f) begin
                if (st == 1) begin emit(imin(m_cnt, RP)); st = 0; end
                else if (st == 2) begin emit(-RP); ncnt = 1; end
                else begin st = 2; ncnt = 1; end
            end
            m_st = st;
        end else begin
            m_st = 0;
            wt = (m_wait != 0) && !chg;
            if (r) begin
                if (a == 0) begin emit(0); m_wait = 0; end
                else begin m_wait = 1; nw = 1; m_a = a; end
            end else if (wt) begin
                if (f && m_wcnt < m_a) begin emit(imin(m_wcnt, H)); m_wait = 0; end
                else if (m_wcnt >= m_a) begin emit(-imin(m_a, H)); m_wait = 0; end
            end
        end
        m_cnt  = ncnt;
        m_wcnt = nw;
        m_age  = f ? 1 : imin(m_age + 1, CAP);
        if (r) m_miss = 0; else if (mset) m_miss = 1;
        m_gap  = r ? 1 : imin(m_gap + 1, CAP);
        m_mode = mn;
    endtask

    task automatic tick();
        bit rl, fl;
        @(negedge clk);
        if (started) begin
            // R1/R2: error value; R3/R10: strobe and sign timing; R4: mode; R9: flag
            chk(perr == m_err, "R1/R2 phase_err", perr, m_err);
            chk(vld == m_valid[0], "R3/R10 err_valid", vld, m_valid);
            chk(up == (m_err > 0), "R3 err_up", up, m_err > 0);
            chk(nem == m_mode[0], "R4 ne_mode", nem, m_mode);
            chk(miss == m_miss[0], "R9 miss_flag", miss, m_miss);
            if (vld) begin
                last_err = perr;
                if (perr == RP) saw_pos_full = 1;
                if (perr == -RP) saw_neg_full = 1;
                if (perr != 5) wrong_in_window++;
            end
            if (miss) saw_miss = 1;
        end
        rl = 0; fl = 0;
        if (gen_en) begin
            if (rph == 0) begin
                if (skipping) skipping = 0;
                else if (skip_req) begin skipping = 1; skip_req = 0; end
            end
            rl = !skipping && (rph < RP / 2);
            fl = (fph < fper / 2);
            rph = (rph + 1) % RP;
            fph = (fph + 1) % fper;
        end
        ref_clk = rl;
        fb_clk  = fl;
        r3 = r2; r2 = r1; r1 = r0; r0 = rl;
        f3 = f2; f2 = f1; f1 = f0; f0 = fl;
        model_step(r2 && !r3, f2 && !f3);
        started = 1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_fb(input int per, input int lag);
        fper = per;
        fph  = (((rph - lag) % per) + per) % per;
    endtask

    initial begin
        rst = 1;
        run(5);
        rst = 0;
        run(2);
        // R10: reset state
        chk(perr == 0 && !vld && !up, "R10 reset outputs", perr, 0);
        chk(!nem && !miss, "R10 reset mode/flag", {nem, miss}, 0);
        // R7: fixed variant starts in nearest-edge mode
        chk(nem_f == 1'b1, "R7 fixed after reset", nem_f, 1);

        gen_en = 1; rph = 0;
        set_fb(RP, 5);
        run(400);
        chk(last_err == 5, "R1 pf lag 5", last_err, 5);
        set_fb(RP, RP - 7);
        run(300);
        chk(last_err == -7, "R1 pf lead 7", last_err, -7);
        set_fb(90, 0);
        run(600);
        chk(saw_pos_full, "R1 slow feedback full-cycle", saw_pos_full, 1);
        set_fb(18, 0);
        run(400);
        chk(saw_neg_full, "R1 fast feedback full-cycle", saw_neg_full, 1);

        set_fb(RP, 5);
        run(200);
        lock = 1;
        run(100);
        chk(nem == 1'b1, "R4 enters nearest-edge on lock", nem, 1);
        chk(nem_s == 1'b0, "R8 slow reference stays pf", nem_s, 0);
        run(200);
        chk(last_err == 5, "R2 ne next edge", last_err, 5);
        set_fb(RP, 30);
        run(200);
        chk(last_err == -10, "R2 ne past edge", last_err, -10);
        set_fb(RP, 20);
        run(200);
        chk(last_err == -H, "R2 ne tie picks past", last_err, -H);

        mcpd = 1;
        run(100);
        chk(nem == 1'b0, "R4 multicycle blocks nearest-edge", nem, 0);
        chk(nem_f == 1'b1, "R7 fixed ignores controls", nem_f, 1);
        mcpd = 0;
        run(100);
        chk(nem == 1'b1, "R4 back to nearest-edge", nem, 1);

        // R9: one missing reference cycle in nearest-edge mode
        set_fb(RP, 5);
        run(200);
        wrong_in_window = 0; saw_miss = 0;
        skip_req = 1;
        run(150);
        chk(saw_miss, "R9 flag raised", saw_miss, 1);
        chk(wrong_in_window == 0, "R9 no false correction", wrong_in_window, 0);
        run(50);
        chk(miss == 1'b0, "R9 flag cleared", miss, 0);

        force_pf = 1;
        run(100);
        chk(nem == 1'b0, "R5 force holds pf", nem, 0);
        force_pf = 0;
        run(100);
        chk(nem == 1'b1, "R5 release returns ne", nem, 1);

        lock = 0;
        run(RP + 4);
        chk(nem == 1'b0, "R6 lock loss to pf", nem, 0);
        chk(nem_f == 1'b1, "R7 fixed keeps ne without lock", nem_f, 1);

        skip_req = 1;
        run(300);
        chk(nem_s == 1'b0, "R8 slow reference at end", nem_s, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule